// File: doc/BRIEF.md
# Keyed-Start Watchdog Timer

This block is a watchdog timer behind a simple 32-bit register bus. A free-running up-counter advances on a tick. The tick is either every clock cycle or the clock divided by a power of two. When the counter wraps past its all-ones value, the block pulses a one-cycle expiry output and reloads the counter from a load register.

Software services the watchdog by writing a new value to a trigger register, which reloads the counter. A single stray write cannot start or stop the timer. Each of those actions needs two exact words written in order to the start/stop register. To arm the timer for N ticks, software loads the complement of N-1.

Each writable timer register has its own pending flag. The flag models the delay of a write crossing into a slower clock domain: while it is set, further writes to that register are dropped.

Top module: `wdog_keyed`

## Requirements
- R1: After reset the timer is stopped, the control, counter, load and pending registers read as zero, and `wdt_expire` is low.
- R2: Registers sit at byte offsets ID 0x00, system config 0x10, control 0x24, counter 0x28, load 0x2C, trigger 0x30, pending 0x34 and start/stop 0x48. The low byte of ID reads the revision parameter. Control bit 5 is the prescaler enable and bits 4:2 are the prescale exponent, and both read back as written.
- R3: With the prescaler enabled, the counter advances once every 2^exponent clock cycles, beginning 2^exponent cycles after start. With it disabled, the counter advances every cycle, beginning one cycle after start.
- R4: When the counter advances from all-ones, `wdt_expire` is high for exactly one cycle and the counter takes the load value. A load of 0xFFFFFFF0 therefore expires 16 ticks after start, and again every 16 ticks.
- R5: Writing 0x0000BBBB and then 0x00004444 to start/stop starts the timer.
- R6: Writing 0x0000AAAA and then 0x00005555 to start/stop stops the timer, and the counter then holds its value.
- R7: A second key word that does not directly follow its matching first word has no effect, and any other written value returns the sequence to its idle state.
- R8: Writing the trigger register with a value that differs from its current contents copies the load value into the counter. Rewriting the same value leaves the counter unchanged.
- R9: Pending bits are bit 0 control, bit 1 counter, bit 2 load, bit 3 trigger and bit 4 start/stop. A bit reads 1 for 4 cycles after an accepted write to its register and then clears.
- R10: A write to a register whose pending bit is set is ignored.
- R11: A write to the counter register sets the count directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data returns on the next cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, held between reads |
| wdt_expire | output | 1 | One-cycle pulse on counter overflow |

## Verification
The hardest case to reach is the overflow itself, because a 32-bit counter normally takes billions of ticks to wrap. The bench writes a near-all-ones load value and copies it into the counter by changing the trigger value. It then starts the timer with the key pair, so expiry arrives within tens of cycles. It counts the cycles to the first and second pulse, both without the prescaler and with it. Each step of a key sequence must wait out the start/stop pending window, so the bench spaces its writes by more than four cycles. It also sends deliberately early writes to show that they are dropped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_ID   = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_SYS  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_TRIG = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 8'h48;

  // pending-bit positions (software decodes these)
  localparam int PB_CTL  = 0;
  localparam int PB_CNT  = 1;
  localparam int PB_LOAD = 2;
  localparam int PB_TRIG = 3;
  localparam int PB_KEY  = 4;
  localparam int NPEND   = 5;

  localparam logic [DATA_W-1:0] KEY_RUN_A  = 32'h0000_BBBB;
  localparam logic [DATA_W-1:0] KEY_RUN_B  = 32'h0000_4444;
  localparam logic [DATA_W-1:0] KEY_HALT_A = 32'h0000_AAAA;
  localparam logic [DATA_W-1:0] KEY_HALT_B = 32'h0000_5555;

  typedef enum logic [1:0] {
    KS_IDLE       = 2'd0,
    KS_RUN_ARMED  = 2'd1,
    KS_HALT_ARMED = 2'd2
  } key_state_t;
endpackage

// File: rtl/wdog_pend.sv
module wdog_pend #(
  parameter int NREG     = 5,
  parameter int PEND_CYC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] req,
  output logic [NREG-1:0] busy,
  output logic [NREG-1:0] accept
);
  localparam int CW = $clog2(PEND_CYC + 1);

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (rst)
        cnt_q <= '0;
      else if (req[i] && cnt_q == '0)
        cnt_q <= CW'(PEND_CYC);
      else if (cnt_q != '0)
        cnt_q <= cnt_q - CW'(1);
    end

    assign busy[i]   = (cnt_q != '0);
    assign accept[i] = req[i] && !busy[i];

    AST_PEND_ARM: assert property (@(posedge clk) disable iff (rst)
      (req[i] && !busy[i]) |=> (cnt_q == CW'(PEND_CYC))); // R9
    AST_PEND_IGNORE: assert property (@(posedge clk) disable iff (rst)
      (req[i] && busy[i]) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R10
  end
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PTV_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_en,
  input  logic [PTV_W-1:0] ptv,
  output logic             tick
);
  localparam int DIV_W = (1 << PTV_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic             wrap;

  assign mask = DIV_W'(({{DIV_W{1'b0}}, 1'b1} << ptv) - 1'b1);
  assign wrap = !pre_en || (div_q >= mask);
  assign tick = run && wrap;

  always_ff @(posedge clk) begin
    if (rst || !run)
      div_q <= '0;
    else if (wrap)
      div_q <= '0;
    else
      div_q <= div_q + DIV_W'(1);
  end

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    !run |=> (div_q == '0)); // R3
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_val,
  output logic              running
);
  key_state_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= KS_IDLE;
      running <= 1'b0;
    end else if (key_wr) begin
      if (key_val == KEY_RUN_A)
        st_q <= KS_RUN_ARMED;
      else if (key_val == KEY_HALT_A)
        st_q <= KS_HALT_ARMED;
      else begin
        st_q <= KS_IDLE;
        if (st_q == KS_RUN_ARMED && key_val == KEY_RUN_B)
          running <= 1'b1;
        if (st_q == KS_HALT_ARMED && key_val == KEY_HALT_B)
          running <= 1'b0;
      end
    end
  end

  AST_START_KEY: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> ($past(st_q) == KS_RUN_ARMED && $past(key_wr)
                        && $past(key_val) == KEY_RUN_B)); // R5
  AST_STOP_KEY: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> ($past(st_q) == KS_HALT_ARMED && $past(key_wr)
                        && $past(key_val) == KEY_HALT_B)); // R6
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int          CNT_W    = 32,
  parameter int          PTV_W    = 3,
  parameter int          PEND_CYC = 4,
  parameter logic [7:0]  REV      = 8'h31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wdt_expire
);
  localparam int CTL_LSB = 2;
  localparam int CTL_EN  = CTL_LSB + PTV_W;

  logic             pre_en_q;
  logic [PTV_W-1:0] ptv_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_q;
  logic [DATA_W-1:0] trig_q;
  logic [DATA_W-1:0] key_q;
  logic [DATA_W-1:0] sys_q;

  logic [NPEND-1:0] req, busy, acc;
  logic             running, tick, trig_reload, ovf;
  logic [DATA_W-1:0] rd_mux;

  assign req[PB_CTL]  = bus_wr && bus_addr == OFS_CTL;
  assign req[PB_CNT]  = bus_wr && bus_addr == OFS_CNT;
  assign req[PB_LOAD] = bus_wr && bus_addr == OFS_LOAD;
  assign req[PB_TRIG] = bus_wr && bus_addr == OFS_TRIG;
  assign req[PB_KEY]  = bus_wr && bus_addr == OFS_KEY;

  wdog_pend #(.NREG(NPEND), .PEND_CYC(PEND_CYC)) u_pend (
    .clk(clk), .rst(rst), .req(req), .busy(busy), .accept(acc)
  );

  wdog_keyseq u_key (
    .clk(clk), .rst(rst), .key_wr(acc[PB_KEY]), .key_val(bus_wdata),
    .running(running)
  );

  wdog_prescale #(.PTV_W(PTV_W)) u_pre (
    .clk(clk), .rst(rst), .run(running), .pre_en(pre_en_q), .ptv(ptv_q),
    .tick(tick)
  );

  assign trig_reload = acc[PB_TRIG] && (bus_wdata != trig_q);
  assign ovf         = tick && (cnt_q == {CNT_W{1'b1}});

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_ID:   rd_mux[7:0] = REV;
      OFS_SYS:  rd_mux = sys_q;
      OFS_CTL:  begin
        rd_mux[CTL_EN] = pre_en_q;
        rd_mux[CTL_EN-1:CTL_LSB] = ptv_q;
      end
      OFS_CNT:  rd_mux[CNT_W-1:0] = cnt_q;
      OFS_LOAD: rd_mux[CNT_W-1:0] = load_q;
      OFS_TRIG: rd_mux = trig_q;
      OFS_PEND: rd_mux[NPEND-1:0] = busy;
      OFS_KEY:  rd_mux = key_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_en_q   <= 1'b0;
      ptv_q      <= '0;
      cnt_q      <= '0;
      load_q     <= '0;
      trig_q     <= '0;
      key_q      <= '0;
      sys_q      <= '0;
      wdt_expire <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      wdt_expire <= 1'b0;
      if (acc[PB_CTL]) begin
        pre_en_q <= bus_wdata[CTL_EN];
        ptv_q    <= bus_wdata[CTL_EN-1:CTL_LSB];
      end
      if (acc[PB_LOAD]) load_q <= bus_wdata[CNT_W-1:0];
      if (acc[PB_TRIG]) trig_q <= bus_wdata;
      if (acc[PB_KEY])  key_q  <= bus_wdata;
      if (bus_wr && bus_addr == OFS_SYS) sys_q <= bus_wdata;

      if (acc[PB_CNT])
        cnt_q <= bus_wdata[CNT_W-1:0];
      else if (trig_reload)
        cnt_q <= load_q;
      else if (ovf) begin
        cnt_q      <= load_q;
        wdt_expire <= 1'b1;
      end else if (tick)
        cnt_q <= cnt_q + CNT_W'(1);

      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  AST_EXPIRE_RELOAD: assert property (@(posedge clk) disable iff (rst)
    wdt_expire |-> (cnt_q == $past(load_q))); // R4
  AST_HALT_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!running && !acc[PB_CNT] && !trig_reload) |=> $stable(cnt_q)); // R6
  AST_SAME_TRIG: assert property (@(posedge clk) disable iff (rst)
    (acc[PB_TRIG] && bus_wdata == trig_q && !running && !acc[PB_CNT])
      |=> $stable(cnt_q)); // R8
endmodule

// File: tb/sim_wdog_keyed.sv
`timescale 1ns/1ps
module sim_wdog_keyed;
  localparam logic [7:0] REV = 8'h31;

  logic        clk = 1'b0;
  logic        rst;
  logic        bus_wr, bus_rd;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        wdt_expire;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  wdog_keyed #(.REV(REV)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_expire(wdt_expire)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wrg(input logic [7:0] a, input logic [31:0] d);
    wr(a, d);
    idle(5);
  endtask

  // cycles from the current negedge until the first expire pulse
  task automatic time_expire(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (wdt_expire && k < 0) k = i;
      if (k >= 0) break;
    end
  endtask

  task automatic is_stopped(output logic st);
    logic [31:0] a, b;
    rd(8'h28, a);
    idle(6);
    rd(8'h28, b);
    st = (a == b);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 expire", {31'd0, wdt_expire}, 32'd0);
    rd(8'h24, d); chk("R1 ctl", d, 32'h0);
    rd(8'h28, d); chk("R1 cnt", d, 32'h0);
    rd(8'h2C, d); chk("R1 load", d, 32'h0);
    rd(8'h34, d); chk("R1 pend", d, 32'h0);
  endtask

  task automatic t_regs_pend();
    logic [31:0] d;
    rd(8'h00, d); chk("R2 id rev", {24'd0, d[7:0]}, {24'd0, REV});
    wr(8'h24, 32'h3C);
    rd(8'h34, d); chk("R9 pend ctl bit0", d, 32'h01);
    idle(5);
    rd(8'h34, d); chk("R9 pend cleared", d, 32'h0);
    rd(8'h24, d); chk("R2 ctl readback", d, 32'h3C);
    wr(8'h24, 32'h20);
    wr(8'h24, 32'h1C);             // lands while pending: dropped
    idle(5);
    rd(8'h24, d); chk("R10 ignored write", d, 32'h20);
    wr(8'h2C, 32'h55);
    rd(8'h34, d); chk("R9 pend load bit2", d, 32'h04);
    idle(5);
    wr(8'h48, 32'h1);
    rd(8'h34, d); chk("R9 pend key bit4", d, 32'h10);
    idle(5);
    wrg(8'h24, 32'h0);
  endtask

  task automatic t_cnt_trig();
    logic [31:0] d;
    wrg(8'h28, 32'h1234);
    rd(8'h28, d); chk("R11 counter write", d, 32'h1234);
    wrg(8'h2C, 32'h200);
    wrg(8'h30, 32'h7);
    rd(8'h28, d); chk("R8 trigger reload", d, 32'h200);
    wrg(8'h28, 32'h100);
    wrg(8'h30, 32'h7);
    rd(8'h28, d); chk("R8 same trigger no effect", d, 32'h100);
    wrg(8'h30, 32'h8);
    rd(8'h28, d); chk("R8 new trigger reload", d, 32'h200);
  endtask

  task automatic t_bad_keys();
    logic st;
    wrg(8'h48, 32'h0000BBBB);
    wrg(8'h48, 32'h00001234);
    wrg(8'h48, 32'h00004444);
    is_stopped(st); chk("R7 broken start", {31'd0, st}, 32'd1);
    wrg(8'h48, 32'h0000BBBB);
    wrg(8'h48, 32'h00005555);
    is_stopped(st); chk("R7 mismatched second", {31'd0, st}, 32'd1);
    wrg(8'h48, 32'h00004444);
    is_stopped(st); chk("R7 lone second word", {31'd0, st}, 32'd1);
  endtask

  task automatic t_run_expire();
    int k;
    logic st;
    wrg(8'h2C, 32'hFFFF_FFF0);
    wrg(8'h30, 32'h9);
    wrg(8'h48, 32'h0000BBBB);
    wr(8'h48, 32'h00004444);
    time_expire(100, k); chk("R5 R4 first expiry cycle", k, 16);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'd0, wdt_expire}, 32'd0);
    time_expire(100, k); chk("R4 reload period", k + 1, 16);
    wrg(8'h48, 32'h0000AAAA);
    wrg(8'h48, 32'h00005555);
    is_stopped(st); chk("R6 stop holds counter", {31'd0, st}, 32'd1);
  endtask

  task automatic t_prescale();
    int k;
    wrg(8'h24, 32'h28);            // enable, exponent 2
    wrg(8'h30, 32'hA);
    wrg(8'h48, 32'h0000BBBB);
    wr(8'h48, 32'h00004444);
    time_expire(400, k); chk("R3 divided expiry cycle", k, 64);
    wrg(8'h48, 32'h0000AAAA);
    wrg(8'h48, 32'h00005555);
  endtask

  initial begin
    bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_regs_pend();
    t_cnt_trig();
    t_bad_keys();
    t_run_expire();
    t_prescale();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule